// File: doc/BRIEF.md
# Shared-Bus SRAM and Flash Controller

This block sits between a synchronous 32-bit host request port and an asynchronous memory module. The module holds a fast SRAM region and a slow flash region. Both regions share one 32-bit data bus and one set of address lines. Each host request carries a word address, a read/write flag, write data and four byte enables. The controller decodes the top address bit into a region, drives that region's chip select and strobes for a number of clock cycles set by parameters, and returns read data with a one-cycle valid pulse.

The two memory types are never selected together. Each type has its own write enable for every byte lane, and the host byte enables pick which lanes fire. After every access, all selects and the output enable return high and the data bus is released for a recovery window. This keeps a read and the write that follows it from driving the shared lines at the same time. Flash command sequences are not interpreted: a flash write is issued as a plain bus cycle, with the flash timing counts.

Top module: `shmem_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, both chip selects, the output enable and all eight lane write enables are high (inactive), `mem_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: Host address bit 19 picks the region: 0 selects the SRAM, where `mem_addr` carries host bits 16..0 and its bits 18..17 are zero, so host bits 18..17 alias; 1 selects the flash, where `mem_addr` carries host bits 18..0. The address is held for the whole access.
- R3: `sram_cs_n` and `flash_cs_n` are never low in the same cycle.
- R4: A read holds the region's chip select and `mem_oe_n` low for exactly RD cycles of that region. It samples `mem_dq_in` at the last of those cycles and presents the word on `rd_data`, with `rd_valid` high for one cycle: the cycle in which the select and output enable return high.
- R5: A write drives the data and the region's chip select for SU cycles with the write enables high. It then holds the selected lanes' write enables low for WP cycles, then keeps the select low and the data and address unchanged for HD cycles. `mem_oe_n` stays high throughout.
- R6: Byte enable bit i (data bits 8i+7..8i) drives only lane i's write enable of the addressed type. The other type's four write enables stay high.
- R7: After each access, both selects and the output enable stay high, and the bus stays released, for at least REC+1 cycles of the finished access's region before the next chip select falls. So a read and the write after it are always separated by idle cycles.
- R8: `req_ready` is high only when no access is in progress. A request is taken only when `req_valid` and `req_ready` are both high, and a `req_valid` pulse while busy causes no memory cycle.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R10: Flash accesses use the flash counts (default RD=24, SU=1, WP=10, HD=2, REC=11 cycles). SRAM accesses use the SRAM counts (default RD=5, SU=1, WP=4, HD=1, REC=1 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address; bit 19 selects the flash |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for data bits 8i+7..8i |
| rd_valid | output | 1 | One-cycle pulse with returned read data |
| rd_data | output | 32 | Read data |
| mem_addr | output | 19 | Shared memory word address |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_in | input | 32 | Data returned by the memory |
| mem_dq_oe | output | 1 | Enables the data bus driver |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| flash_cs_n | output | 1 | Flash chip select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| sram_we_n | output | 4 | SRAM lane write enables, active low |
| flash_we_n | output | 4 | Flash lane write enables, active low |

## Verification
Suppose the sequencer's cycle counter is loaded from the wrong region's counts, or is off by one. Then the run length of the output enable or the write pulse differs from the expected count on the very access where the fault occurs, and the bench measures those lengths at every edge of the strobes. A wrong lane mapping, or a select from the wrong type, corrupts the memory model. It shows up as a mismatched word on the next read-back of that address, a few tens of cycles later. A stuck or skipped recovery state shortens the idle gap before the next chip select falls, and that gap is checked on every access.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    localparam int TM_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RECOVER
    } seq_state_e;

    typedef enum logic {
        RGN_SRAM  = 1'b0,
        RGN_FLASH = 1'b1
    } region_e;

    typedef struct packed {
        logic [TM_W-1:0] rd;
        logic [TM_W-1:0] su;
        logic [TM_W-1:0] wp;
        logic [TM_W-1:0] hd;
        logic [TM_W-1:0] rec;
    } timing_t;

endpackage

// File: rtl/shmem_region_decode.sv
module shmem_region_decode
    import shmem_pkg::*;
#(
    parameter int HOST_AW = 20,
    parameter int MEM_AW  = 19,
    parameter int SRAM_AW = 17
) (
    input  logic [HOST_AW-1:0] host_addr,
    output region_e            region,
    output logic [MEM_AW-1:0]  mem_addr
);

    localparam int SEL_BIT = HOST_AW - 1;

    logic [MEM_AW-1:0] sram_addr;

    always_comb begin
        sram_addr                = '0;
        sram_addr[SRAM_AW-1:0]   = host_addr[SRAM_AW-1:0];
        region                   = host_addr[SEL_BIT] ? RGN_FLASH : RGN_SRAM;
        mem_addr                 = (region == RGN_FLASH) ? host_addr[MEM_AW-1:0] : sram_addr;
    end

endmodule

// File: rtl/shmem_timing_sel.sv
module shmem_timing_sel
    import shmem_pkg::*;
#(
    parameter int S_RD  = 5,
    parameter int S_SU  = 1,
    parameter int S_WP  = 4,
    parameter int S_HD  = 1,
    parameter int S_REC = 1,
    parameter int F_RD  = 24,
    parameter int F_SU  = 1,
    parameter int F_WP  = 10,
    parameter int F_HD  = 2,
    parameter int F_REC = 11
) (
    input  region_e region,
    output timing_t tm
);

    localparam timing_t SRAM_TM = '{
        rd:  TM_W'(S_RD),
        su:  TM_W'(S_SU),
        wp:  TM_W'(S_WP),
        hd:  TM_W'(S_HD),
        rec: TM_W'(S_REC)
    };

    localparam timing_t FLASH_TM = '{
        rd:  TM_W'(F_RD),
        su:  TM_W'(F_SU),
        wp:  TM_W'(F_WP),
        hd:  TM_W'(F_HD),
        rec: TM_W'(F_REC)
    };

    always_comb begin
        tm = (region == RGN_FLASH) ? FLASH_TM : SRAM_TM;
    end

endmodule

// File: rtl/shmem_lane_we.sv
module shmem_lane_we
    import shmem_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strobe,
    input  region_e          region,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] sram_we_n,
    output logic [LANES-1:0] flash_we_n
);

    logic hit_sram;
    logic hit_flash;

    assign hit_sram  = strobe && (region == RGN_SRAM);
    assign hit_flash = strobe && (region == RGN_FLASH);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign sram_we_n[g]  = !(hit_sram  && be[g]);
        assign flash_we_n[g] = !(hit_flash && be[g]);
    end

endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
    import shmem_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int HOST_AW = 20,
    parameter int MEM_AW  = 19,
    parameter int SRAM_AW = 17,
    parameter int S_RD    = 5,
    parameter int S_SU    = 1,
    parameter int S_WP    = 4,
    parameter int S_HD    = 1,
    parameter int S_REC   = 1,
    parameter int F_RD    = 24,
    parameter int F_SU    = 1,
    parameter int F_WP    = 10,
    parameter int F_HD    = 2,
    parameter int F_REC   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [HOST_AW-1:0]   req_addr,
    input  logic [LANES*8-1:0]   req_wdata,
    input  logic [LANES-1:0]     req_be,
    output logic                 rd_valid,
    output logic [LANES*8-1:0]   rd_data,
    output logic [MEM_AW-1:0]    mem_addr,
    output logic [LANES*8-1:0]   mem_dq_out,
    input  logic [LANES*8-1:0]   mem_dq_in,
    output logic                 mem_dq_oe,
    output logic                 sram_cs_n,
    output logic                 flash_cs_n,
    output logic                 mem_oe_n,
    output logic [LANES-1:0]     sram_we_n,
    output logic [LANES-1:0]     flash_we_n
);

    localparam int DATA_W = LANES * 8;

    typedef struct packed {
        seq_state_e         state;
        region_e            region;
        logic [MEM_AW-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   be;
        logic [TM_W-1:0]    cnt;
        logic               sram_cs_n;
        logic               flash_cs_n;
        logic               oe_n;
        logic               dq_oe;
        logic               strobe;
        logic [DATA_W-1:0]  rd_data;
        logic               rd_valid;
    } seq_regs_t;

    localparam seq_regs_t RESET_REGS = '{
        state:      ST_IDLE,
        region:     RGN_SRAM,
        addr:       '0,
        wdata:      '0,
        be:         '0,
        cnt:        '0,
        sram_cs_n:  1'b1,
        flash_cs_n: 1'b1,
        oe_n:       1'b1,
        dq_oe:      1'b0,
        strobe:     1'b0,
        rd_data:    '0,
        rd_valid:   1'b0
    };

    seq_regs_t r_d;
    seq_regs_t r_q;

    region_e            dec_region;
    logic [MEM_AW-1:0]  dec_addr;
    timing_t            req_tm;
    timing_t            cur_tm;

    // Address decode of the incoming request
    shmem_region_decode #(
        .HOST_AW (HOST_AW),
        .MEM_AW  (MEM_AW),
        .SRAM_AW (SRAM_AW)
    ) i_decode (
        .host_addr (req_addr),
        .region    (dec_region),
        .mem_addr  (dec_addr)
    );

    // Counts for the request being accepted
    shmem_timing_sel #(
        .S_RD (S_RD), .S_SU (S_SU), .S_WP (S_WP), .S_HD (S_HD), .S_REC (S_REC),
        .F_RD (F_RD), .F_SU (F_SU), .F_WP (F_WP), .F_HD (F_HD), .F_REC (F_REC)
    ) i_tm_req (
        .region (dec_region),
        .tm     (req_tm)
    );

    // Counts for the access in progress
    shmem_timing_sel #(
        .S_RD (S_RD), .S_SU (S_SU), .S_WP (S_WP), .S_HD (S_HD), .S_REC (S_REC),
        .F_RD (F_RD), .F_SU (F_SU), .F_WP (F_WP), .F_HD (F_HD), .F_REC (F_REC)
    ) i_tm_cur (
        .region (r_q.region),
        .tm     (cur_tm)
    );

    shmem_lane_we #(
        .LANES (LANES)
    ) i_lanes (
        .strobe     (r_q.strobe),
        .region     (r_q.region),
        .be         (r_q.be),
        .sram_we_n  (sram_we_n),
        .flash_we_n (flash_we_n)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.region     = dec_region;
                    r_d.addr       = dec_addr;
                    r_d.wdata      = req_wdata;
                    r_d.be         = req_be;
                    r_d.sram_cs_n  = (dec_region != RGN_SRAM);
                    r_d.flash_cs_n = (dec_region != RGN_FLASH);
                    if (req_write) begin
                        r_d.state = ST_WSETUP;
                        r_d.dq_oe = 1'b1;
                        r_d.cnt   = req_tm.su - 1'b1;
                    end else begin
                        r_d.state = ST_READ;
                        r_d.oe_n  = 1'b0;
                        r_d.cnt   = req_tm.rd - 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (r_q.cnt == '0) begin
                    r_d.rd_data    = mem_dq_in;
                    r_d.rd_valid   = 1'b1;
                    r_d.oe_n       = 1'b1;
                    r_d.sram_cs_n  = 1'b1;
                    r_d.flash_cs_n = 1'b1;
                    r_d.state      = ST_RECOVER;
                    r_d.cnt        = cur_tm.rec - 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WSETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.strobe = 1'b1;
                    r_d.state  = ST_WPULSE;
                    r_d.cnt    = cur_tm.wp - 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WPULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.strobe = 1'b0;
                    r_d.state  = ST_WHOLD;
                    r_d.cnt    = cur_tm.hd - 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.sram_cs_n  = 1'b1;
                    r_d.flash_cs_n = 1'b1;
                    r_d.dq_oe      = 1'b0;
                    r_d.state      = ST_RECOVER;
                    r_d.cnt        = cur_tm.rec - 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d = RESET_REGS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == ST_IDLE);
    assign rd_valid   = r_q.rd_valid;
    assign rd_data    = r_q.rd_data;
    assign mem_addr   = r_q.addr;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
    assign sram_cs_n  = r_q.sram_cs_n;
    assign flash_cs_n = r_q.flash_cs_n;
    assign mem_oe_n   = r_q.oe_n;

endmodule

// File: rtl/shmem_ctrl_chk.sv
module shmem_ctrl_chk #(
    parameter int LANES  = 4,
    parameter int MEM_AW = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               rd_valid,
    input logic [MEM_AW-1:0]  mem_addr,
    input logic [LANES*8-1:0] mem_dq_out,
    input logic               mem_dq_oe,
    input logic               sram_cs_n,
    input logic               flash_cs_n,
    input logic               mem_oe_n,
    input logic [LANES-1:0]   sram_we_n,
    input logic [LANES-1:0]   flash_we_n
);

    logic sram_we_any;
    logic flash_we_any;
    logic we_any;

    assign sram_we_any  = (sram_we_n  != '1);
    assign flash_we_any = (flash_we_n != '1);
    assign we_any       = sram_we_any || flash_we_any;

    a_r3_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_cs_n && !flash_cs_n));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r6_one_type_we: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_any |-> !flash_we_any);

    a_r5_sram_we_framed: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_any |-> (!sram_cs_n && mem_dq_oe && mem_oe_n));

    a_r5_flash_we_framed: assert property (@(posedge clk) disable iff (!rst_n)
        flash_we_any |-> (!flash_cs_n && mem_dq_oe && mem_oe_n));

    a_r5_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (we_any && $past(we_any)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && flash_cs_n && mem_oe_n && !mem_dq_oe));

    a_r7_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (sram_cs_n && flash_cs_n));

endmodule

bind shmem_ctrl shmem_ctrl_chk #(
    .LANES  (LANES),
    .MEM_AW (MEM_AW)
) i_shmem_ctrl_chk (.*);

// File: tb/test_shmem_ctrl.sv
`timescale 1ns/1ps
module test_shmem_ctrl;

    localparam int S_RD = 5,  S_SU = 1, S_WP = 4,  S_HD = 1, S_REC = 1;
    localparam int F_RD = 24, F_SU = 1, F_WP = 10, F_HD = 2, F_REC = 11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [19:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_be;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [18:0] mem_addr;
    logic [31:0] mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, sram_cs_n, flash_cs_n, mem_oe_n;
    logic [3:0]  sram_we_n, flash_we_n;

    always #2.5 clk = ~clk;

    shmem_ctrl #(
        .S_RD (S_RD), .S_SU (S_SU), .S_WP (S_WP), .S_HD (S_HD), .S_REC (S_REC),
        .F_RD (F_RD), .F_SU (F_SU), .F_WP (F_WP), .F_HD (F_HD), .F_REC (F_REC)
    ) i_shmem_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .mem_addr (mem_addr), .mem_dq_out (mem_dq_out), .mem_dq_in (mem_dq_in),
        .mem_dq_oe (mem_dq_oe), .sram_cs_n (sram_cs_n), .flash_cs_n (flash_cs_n),
        .mem_oe_n (mem_oe_n), .sram_we_n (sram_we_n), .flash_we_n (flash_we_n)
    );

    // Memory models (written only through the strobes) and host-side reference
    logic [31:0] sram_m  [logic [18:0]];
    logic [31:0] flash_m [logic [18:0]];
    logic [31:0] ref_m   [logic [19:0]];
    logic [31:0] dq_model;
    assign mem_dq_in = dq_model;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] exp_q [$];
    logic [18:0] exp_addr;
    logic [3:0]  exp_be;
    bit          exp_fl;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] norm(input logic [19:0] a);
        return a[19] ? a : {3'b000, a[16:0]};
    endfunction

    function automatic logic [31:0] ref_get(input logic [19:0] a);
        return ref_m.exists(norm(a)) ? ref_m[norm(a)] : 32'h0;
    endfunction

    function automatic logic [31:0] sram_get(input logic [18:0] a);
        return sram_m.exists(a) ? sram_m[a] : 32'h0;
    endfunction

    function automatic logic [31:0] flash_get(input logic [18:0] a);
        return flash_m.exists(a) ? flash_m[a] : 32'h0;
    endfunction

    // Driver: issues one request and records what the monitor must see
    task automatic access(input bit wr, input logic [19:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        exp_addr  = a[19] ? a[18:0] : {2'b00, a[16:0]};
        exp_be    = be;
        exp_fl    = a[19];
        if (wr) begin
            w = ref_get(a);
            for (int i = 0; i < 4; i++) if (be[i]) w[8*i +: 8] = d[8*i +: 8];
            ref_m[norm(a)] = w;
        end else begin
            exp_q.push_back(ref_get(a));
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor state
    logic [3:0]  p_swe, p_fwe;
    logic        p_oe, p_any;
    logic        any_cs, we_low, p_we_low;
    int          oe_run, we_run, su_run, hd_run, gap, last_rec;
    bit          seen, cur_fl, in_write, after_we;
    logic [31:0] tmp, e;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_swe = '1; p_fwe = '1; p_oe = 1'b1; p_any = 1'b0;
            oe_run = 0; we_run = 0; su_run = 0; hd_run = 0; gap = 0; last_rec = 0;
            seen = 0; cur_fl = 0; in_write = 0; after_we = 0;
            dq_model = 32'h0BAD_F00D;
        end else begin
            any_cs   = !sram_cs_n || !flash_cs_n;
            we_low   = (sram_we_n & flash_we_n) != 4'hF;
            p_we_low = (p_swe & p_fwe) != 4'hF;

            chk(!(!sram_cs_n && !flash_cs_n), "R3 both selects low", {30'b0, sram_cs_n, flash_cs_n}, 32'h1);
            if (!mem_oe_n) chk(!mem_dq_oe, "R9 driver on during output enable", {31'b0, mem_dq_oe}, 32'h0);

            // End of write on each lane stores the lane into the model
            for (int i = 0; i < 4; i++) begin
                if (!p_swe[i] && sram_we_n[i]) begin
                    tmp = sram_get(mem_addr); tmp[8*i +: 8] = mem_dq_out[8*i +: 8]; sram_m[mem_addr] = tmp;
                end
                if (!p_fwe[i] && flash_we_n[i]) begin
                    tmp = flash_get(mem_addr); tmp[8*i +: 8] = mem_dq_out[8*i +: 8]; flash_m[mem_addr] = tmp;
                end
            end

            // Scoreboard: read results
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected rd_valid", rd_data, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R4 read data", rd_data, e);
                end
            end

            // Select falls: gap and address
            if (any_cs && !p_any) begin
                if (seen) chk(gap >= last_rec + 1, "R7 recovery gap", gap, last_rec + 1);
                chk(mem_addr == exp_addr, "R2 memory address", {13'b0, mem_addr}, {13'b0, exp_addr});
                chk(!flash_cs_n == exp_fl, "R2 region select", {31'b0, !flash_cs_n}, {31'b0, exp_fl});
                cur_fl = !flash_cs_n; seen = 1; su_run = 0; hd_run = 0; in_write = 0; after_we = 0;
            end
            if (!any_cs) begin
                if (p_any) gap = 1; else gap++;
            end

            // Output enable length and valid pulse
            if (!mem_oe_n) begin
                oe_run++;
            end else if (!p_oe) begin
                chk(oe_run == (cur_fl ? F_RD : S_RD), cur_fl ? "R10 flash read length" : "R4 sram read length",
                    oe_run, cur_fl ? F_RD : S_RD);
                chk(rd_valid && !any_cs, "R4 valid with release", {30'b0, rd_valid, any_cs}, 32'h2);
                oe_run = 0;
            end

            // Write setup, pulse and hold
            if (any_cs && !we_low && !in_write) su_run++;
            if (we_low && !p_we_low) begin
                chk(su_run == (cur_fl ? F_SU : S_SU), "R5 setup cycles", su_run, cur_fl ? F_SU : S_SU);
                chk(sram_we_n == (exp_fl ? 4'hF : ~exp_be), "R6 sram lanes", {28'b0, sram_we_n},
                    {28'b0, exp_fl ? 4'hF : ~exp_be});
                chk(flash_we_n == (exp_fl ? ~exp_be : 4'hF), "R6 flash lanes", {28'b0, flash_we_n},
                    {28'b0, exp_fl ? ~exp_be : 4'hF});
                chk(mem_oe_n && mem_dq_oe, "R5 bus driven, output enable high", {30'b0, mem_oe_n, mem_dq_oe}, 32'h3);
                in_write = 1; we_run = 0;
            end
            if (we_low) we_run++;
            if (!we_low && p_we_low) begin
                chk(we_run == (cur_fl ? F_WP : S_WP), cur_fl ? "R10 flash pulse" : "R5 sram pulse",
                    we_run, cur_fl ? F_WP : S_WP);
                after_we = 1; hd_run = 0;
            end
            if (any_cs && after_we) hd_run++;
            if (!any_cs && p_any) begin
                if (after_we) chk(hd_run == (cur_fl ? F_HD : S_HD), "R5 hold cycles", hd_run, cur_fl ? F_HD : S_HD);
                last_rec = cur_fl ? F_REC : S_REC;
            end

            // Memory model read path, ready before the capturing edge
            if (!mem_oe_n && !sram_cs_n)       dq_model = sram_get(mem_addr);
            else if (!mem_oe_n && !flash_cs_n) dq_model = flash_get(mem_addr);
            else                               dq_model = 32'h0BAD_F00D;

            p_swe = sram_we_n; p_fwe = flash_we_n; p_oe = mem_oe_n; p_any = any_cs;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sram_cs_n && flash_cs_n && mem_oe_n, "R1 selects in reset", {29'b0, sram_cs_n, flash_cs_n, mem_oe_n}, 32'h7);
        chk(sram_we_n == 4'hF && flash_we_n == 4'hF, "R1 write enables in reset", {24'b0, sram_we_n, flash_we_n}, 32'hFF);
        chk(!mem_dq_oe && !rd_valid, "R1 bus and valid in reset", {30'b0, mem_dq_oe, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
        chk(sram_cs_n && flash_cs_n && mem_oe_n && !mem_dq_oe, "R1 idle after reset",
            {28'b0, sram_cs_n, flash_cs_n, mem_oe_n, mem_dq_oe}, 32'hE);

        // SRAM full words, several patterns (R4, R5)
        access(1, 20'h00010, 32'hA5A5_5A5A, 4'hF);
        access(1, 20'h1FFFF, 32'hFFFF_FFFF, 4'hF);
        access(1, 20'h00000, 32'h0000_0001, 4'hF);
        access(0, 20'h00010, '0, 4'hF);
        access(0, 20'h1FFFF, '0, 4'hF);
        access(0, 20'h00000, '0, 4'hF);

        // Byte lanes (R6)
        access(1, 20'h00020, 32'h1111_1111, 4'hF);
        access(1, 20'h00020, 32'hAAAA_AA22, 4'b0001);
        access(1, 20'h00020, 32'h33BB_BBBB, 4'b1000);
        access(1, 20'h00020, 32'hCC44_CC55, 4'b0101);
        access(0, 20'h00020, '0, 4'hF);
        access(1, 20'h00021, 32'hDEAD_BEEF, 4'b0000);
        access(0, 20'h00021, '0, 4'hF);

        // Flash region (R10) and region separation (R2, R3)
        access(1, 20'h80020, 32'hF1A5_0001, 4'hF);
        access(1, 20'hFFFFF, 32'h0123_4567, 4'b0110);
        access(0, 20'h80020, '0, 4'hF);
        access(0, 20'hFFFFF, '0, 4'hF);
        access(0, 20'h00020, '0, 4'hF);

        // SRAM aliasing of host bits 18..17 (R2)
        access(1, 20'h60030, 32'h7777_0030, 4'hF);
        access(0, 20'h00030, '0, 4'hF);
        access(0, 20'h20030, '0, 4'hF);

        // Read directly followed by write, both regions (R7)
        access(0, 20'h00010, '0, 4'hF);
        access(1, 20'h00011, 32'h5555_AAAA, 4'hF);
        access(0, 20'h80020, '0, 4'hF);
        access(1, 20'h00012, 32'h0F0F_F0F0, 4'hF);
        access(0, 20'h00011, '0, 4'hF);
        access(0, 20'h00012, '0, 4'hF);

        // Request while busy is ignored (R8)
        access(1, 20'h00040, 32'h4040_4040, 4'hF);
        chk(!req_ready, "R8 ready low while busy", {31'b0, req_ready}, 32'h0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00041; req_wdata = 32'hBAD0_BAD0; req_be = 4'hF;
        @(negedge clk);
        req_valid = 1'b0;
        access(0, 20'h00041, '0, 4'hF);
        access(0, 20'h00040, '0, 4'hF);

        repeat (60) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule